// File: doc/BRIEF.md
# Receive FIFO with Dword Burst Drain

This block is the receive half of a classic byte-oriented serial port, reduced to its storage and host-facing side. A deserializer delivers bytes on a one-cycle valid strobe. Each byte carries a parity-error tag and a framing-error tag. The bytes are queued in a 64-entry FIFO. A memory-mapped host reads the queue back in one of two ways: one byte per access through a byte data register, or up to four bytes per access through a wide burst data register.

A single 32-bit status word gives the host, in one read, everything it needs to plan a drain. The word holds the number of bytes queued, an interrupt flag that reads as one when nothing is pending, and a copy of the usual line-status flags. Those flags are data ready, sticky overrun, the error tags of the head byte, and a summary bit that is set while any queued byte is tagged. The host normally reads the status word first, takes dwords while four or more bytes remain, and then takes the rest a byte at a time. A write to the FIFO control register with its reset bit set empties the queue and clears the overrun condition.

Host accesses use a plain strobe, address and data interface. Read data is combinational from the current state. A read that removes bytes takes effect at the next rising clock edge.

Top module: `uart_rx_burst_fifo`

## Requirements
- R1: Status word (offset 0x9C) bits 7:0 hold the number of bytes currently queued (0 to 64). After reset the queue is empty.
- R2: Status bit 20 reads 1 exactly when no interrupt is pending, that is, the queue is empty and overrun is clear. Status bit 24 (data ready) is 1 whenever the queue is not empty.
- R3: A byte that arrives while 64 bytes are queued is discarded and sets status bit 25 (overrun). The bit stays set until a FIFO control reset.
- R4: Status bit 26 is the parity tag and bit 27 the framing tag of the oldest queued byte. Both read 0 when the queue is empty.
- R5: Status bit 31 is 1 while at least one queued byte carries a parity or framing tag.
- R6: A read of the burst register (offset 0xA4) with four or more bytes queued returns the four oldest bytes, the oldest in bits 7:0 and the fourth oldest in bits 31:24, and removes all four.
- R7: A burst read with fewer than four bytes queued returns the queued bytes in the lowest lanes and zero in the other lanes, and removes only the bytes it returned.
- R8: A read of the byte register (offset 0x00) returns the oldest byte in bits 7:0 with zero above it, and removes that byte. On an empty queue it returns zero and removes nothing.
- R9: A write to the FIFO control register (offset 0x02) with bit 1 set (for example 0x43) empties the queue and clears overrun at the next edge. A byte arriving in that cycle is discarded. A write with bit 1 clear changes nothing.
- R10: A status read removes no byte. Status bits 19:8 and 23:21, and reads of any unmapped offset, return zero.
- R11: A byte arrival and a draining read in the same cycle both take effect. Fullness for the arrival is judged on the count before the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One received byte is offered this cycle |
| rx_byte | input | 8 | Received byte value |
| rx_perr | input | 1 | Parity-error tag of the offered byte |
| rx_ferr | input | 1 | Framing-error tag of the offered byte |
| acc_rd | input | 1 | Host read strobe |
| acc_wr | input | 1 | Host write strobe |
| acc_addr | input | ADDR_W | Host register offset |
| acc_wdata | input | 8 | Host write data |
| acc_rdata | output | BUS_W | Host read data, valid while acc_rd is high |

## Verification
Directed sequences are run first. One queues six bytes with a tag in the middle, so that a full burst and then a partial burst separate lane order, zero fill and the tag summary clearing once the tagged byte leaves. One reads the byte register on an empty queue, and one pushes past 64 bytes and then issues control writes with the reset bit clear and then set, with a byte arriving in the same cycle. A full queue drained while a byte arrives separates a fullness test taken before the pop from one taken after it. A long random mix of arrivals, tags and all access kinds is then compared against a queue-based model on every read. This catches drift in the count, the head tags and the error summary that the short directed runs cannot reach.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

   typedef struct packed {
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } rx_entry_t;

   localparam int ST_INT_NONE = 20;
   localparam int ST_DREADY   = 24;
   localparam int ST_OVERRUN  = 25;
   localparam int ST_PARITY   = 26;
   localparam int ST_FRAMING  = 27;
   localparam int ST_ANYERR   = 31;
   localparam int ST_WORD_W   = 32;

endpackage

// File: rtl/rxb_ring.sv
module rxb_ring
   import uart_rxb_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int LANES = 4,
   parameter int CNT_W = 7,
   parameter int POP_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push,
   input  rx_entry_t             push_entry,
   input  logic                  flush,
   input  logic [POP_W-1:0]      pop_n,
   output logic [CNT_W-1:0]      count,
   output logic                  full,
   output rx_entry_t [LANES-1:0] lane_q
);

   localparam int  PTR_W   = $clog2(DEPTH);
   localparam bit  IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] wr_ptr_nx;
   logic [PTR_W-1:0] adv [LANES+1];
   rx_entry_t        mem [DEPTH];

   generate
      if (IS_POW2) begin : g_mask_wrap
         for (genvar k = 0; k <= LANES; k++) begin : g_adv
            assign adv[k] = rd_ptr + PTR_W'(k);
         end
         assign wr_ptr_nx = wr_ptr + PTR_W'(1);
      end else begin : g_mod_wrap
         localparam logic [PTR_W:0] DEPTH_X = (PTR_W+1)'(DEPTH);
         for (genvar k = 0; k <= LANES; k++) begin : g_adv
            logic [PTR_W:0] s;
            assign s      = {1'b0, rd_ptr} + (PTR_W+1)'(k);
            assign adv[k] = (s >= DEPTH_X) ? PTR_W'(s - DEPTH_X) : s[PTR_W-1:0];
         end
         assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      end
   endgenerate

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_q[i] = mem[adv[i]];
      end
   endgenerate

   assign full = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_ptr_nx;
         end
         rd_ptr <= adv[pop_n];
         count  <= count + CNT_W'(push) - CNT_W'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) begin
         mem[wr_ptr] <= push_entry;
      end
   end

endmodule

// File: rtl/rxb_err_track.sv
module rxb_err_track #(
   parameter int LANES = 4,
   parameter int CNT_W = 7,
   parameter int POP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_err,
   input  logic             push_drop,
   input  logic             flush,
   input  logic [POP_W-1:0] pop_n,
   input  logic [LANES-1:0] lane_err,
   output logic             err_any,
   output logic             overrun
);

   logic [CNT_W-1:0] err_cnt;
   logic [CNT_W-1:0] popped_err;

   always_comb begin
      popped_err = '0;
      for (int i = 0; i < LANES; i++) begin
         if ((POP_W'(i) < pop_n) && lane_err[i]) begin
            popped_err = popped_err + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_cnt <= '0;
         overrun <= 1'b0;
      end else if (flush) begin
         err_cnt <= '0;
         overrun <= 1'b0;
      end else begin
         err_cnt <= err_cnt + CNT_W'(push_err) - popped_err;
         if (push_drop) begin
            overrun <= 1'b1;
         end
      end
   end

   assign err_any = (err_cnt != '0);

endmodule

// File: rtl/rxb_host_port.sv
module rxb_host_port
   import uart_rxb_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUS_W     = 32,
   parameter int LANES     = 4,
   parameter int CNT_W     = 7,
   parameter int POP_W     = 3,
   parameter int OFS_BYTE  = 'h00,
   parameter int OFS_CTRL  = 'h02,
   parameter int OFS_STAT  = 'h9C,
   parameter int OFS_BURST = 'hA4,
   parameter int RST_BIT   = 1
) (
   input  logic                  acc_rd,
   input  logic                  acc_wr,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [7:0]            acc_wdata,
   input  logic [CNT_W-1:0]      count,
   input  rx_entry_t [LANES-1:0] lane_q,
   input  logic                  overrun,
   input  logic                  err_any,
   output logic [BUS_W-1:0]      acc_rdata,
   output logic [POP_W-1:0]      pop_n,
   output logic                  flush
);

   logic             hit_byte;
   logic             hit_stat;
   logic             hit_burst;
   logic             not_empty;
   logic [POP_W-1:0] avail;

   assign hit_byte  = acc_rd && (acc_addr == ADDR_W'(OFS_BYTE));
   assign hit_stat  = acc_rd && (acc_addr == ADDR_W'(OFS_STAT));
   assign hit_burst = acc_rd && (acc_addr == ADDR_W'(OFS_BURST));
   assign flush     = acc_wr && (acc_addr == ADDR_W'(OFS_CTRL)) && acc_wdata[RST_BIT];
   assign not_empty = (count != '0);
   assign avail     = (count >= CNT_W'(LANES)) ? POP_W'(LANES) : POP_W'(count);

   always_comb begin
      acc_rdata = '0;
      pop_n     = '0;
      if (hit_stat) begin
         acc_rdata[CNT_W-1:0]   = count;
         acc_rdata[ST_INT_NONE] = !not_empty && !overrun;
         acc_rdata[ST_DREADY]   = not_empty;
         acc_rdata[ST_OVERRUN]  = overrun;
         acc_rdata[ST_PARITY]   = not_empty && lane_q[0].perr;
         acc_rdata[ST_FRAMING]  = not_empty && lane_q[0].ferr;
         acc_rdata[ST_ANYERR]   = err_any;
      end else if (hit_burst) begin
         for (int i = 0; i < LANES; i++) begin
            if (POP_W'(i) < avail) begin
               acc_rdata[8*i +: 8] = lane_q[i].data;
            end
         end
         pop_n = avail;
      end else if (hit_byte) begin
         if (not_empty) begin
            acc_rdata[7:0] = lane_q[0].data;
            pop_n          = POP_W'(1);
         end
      end
   end

endmodule

// File: rtl/uart_rx_burst_fifo.sv
module uart_rx_burst_fifo
   import uart_rxb_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int ADDR_W    = 8,
   parameter int BUS_W     = 32,
   parameter int OFS_BYTE  = 'h00,
   parameter int OFS_CTRL  = 'h02,
   parameter int OFS_STAT  = 'h9C,
   parameter int OFS_BURST = 'hA4,
   parameter int RST_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [7:0]        acc_wdata,
   output logic [BUS_W-1:0]  acc_rdata
);

   localparam int LANES = BUS_W / 8;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int POP_W = $clog2(LANES + 1);

   generate
      if (DEPTH < 2 || CNT_W > 8) begin : g_bad_depth
         $error("DEPTH must lie in 2..255 so the count fits the 8-bit status field");
      end
      if (BUS_W < ST_WORD_W || (BUS_W % 8) != 0) begin : g_bad_bus
         $error("BUS_W must be a multiple of 8 and at least 32");
      end
      if (LANES >= DEPTH) begin : g_bad_lanes
         $error("A burst must be narrower than the FIFO depth");
      end
      if (RST_BIT < 0 || RST_BIT > 7) begin : g_bad_rst
         $error("RST_BIT must address a bit of the control byte");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must reach the highest register offset");
      end
   endgenerate

   rx_entry_t             in_entry;
   rx_entry_t [LANES-1:0] lane_q;
   logic [LANES-1:0]      lane_err;
   logic [CNT_W-1:0]      fill_cnt;
   logic [POP_W-1:0]      pop_n;
   logic                  full;
   logic                  flush;
   logic                  push_acc;
   logic                  push_drop;
   logic                  err_any;
   logic                  ovr_flag;

   assign in_entry  = '{ferr: rx_ferr, perr: rx_perr, data: rx_byte};
   assign push_acc  = rx_valid && !full && !flush;
   assign push_drop = rx_valid && full && !flush;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_err_lane
         assign lane_err[i] = lane_q[i].perr || lane_q[i].ferr;
      end
   endgenerate

   rxb_ring #(
      .DEPTH (DEPTH),
      .LANES (LANES),
      .CNT_W (CNT_W),
      .POP_W (POP_W)
   ) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push_acc),
      .push_entry (in_entry),
      .flush      (flush),
      .pop_n      (pop_n),
      .count      (fill_cnt),
      .full       (full),
      .lane_q     (lane_q)
   );

   rxb_err_track #(
      .LANES (LANES),
      .CNT_W (CNT_W),
      .POP_W (POP_W)
   ) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_err  (push_acc && (rx_perr || rx_ferr)),
      .push_drop (push_drop),
      .flush     (flush),
      .pop_n     (pop_n),
      .lane_err  (lane_err),
      .err_any   (err_any),
      .overrun   (ovr_flag)
   );

   rxb_host_port #(
      .ADDR_W    (ADDR_W),
      .BUS_W     (BUS_W),
      .LANES     (LANES),
      .CNT_W     (CNT_W),
      .POP_W     (POP_W),
      .OFS_BYTE  (OFS_BYTE),
      .OFS_CTRL  (OFS_CTRL),
      .OFS_STAT  (OFS_STAT),
      .OFS_BURST (OFS_BURST),
      .RST_BIT   (RST_BIT)
   ) u_host (
      .acc_rd    (acc_rd),
      .acc_wr    (acc_wr),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .count     (fill_cnt),
      .lane_q    (lane_q),
      .overrun   (ovr_flag),
      .err_any   (err_any),
      .acc_rdata (acc_rdata),
      .pop_n     (pop_n),
      .flush     (flush)
   );

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
   parameter int DEPTH     = 64,
   parameter int ADDR_W    = 8,
   parameter int BUS_W     = 32,
   parameter int LANES     = 4,
   parameter int CNT_W     = 7,
   parameter int OFS_BYTE  = 'h00,
   parameter int OFS_CTRL  = 'h02,
   parameter int OFS_STAT  = 'h9C,
   parameter int OFS_BURST = 'hA4,
   parameter int RST_BIT   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              acc_rd,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [7:0]        acc_wdata,
   input logic [BUS_W-1:0]  acc_rdata,
   input logic [CNT_W-1:0]  count,
   input logic              overrun
);

   logic wr_reset;
   logic rd_burst;
   logic rd_byte;
   logic rd_stat;

   assign wr_reset = acc_wr && (acc_addr == ADDR_W'(OFS_CTRL)) && acc_wdata[RST_BIT];
   assign rd_burst = acc_rd && (acc_addr == ADDR_W'(OFS_BURST));
   assign rd_byte  = acc_rd && (acc_addr == ADDR_W'(OFS_BYTE));
   assign rd_stat  = acc_rd && (acc_addr == ADDR_W'(OFS_STAT));

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R1

   AST_EMPTY_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && count == '0 && !overrun) |-> acc_rdata[20] && !acc_rdata[24]); // R2

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && count == CNT_W'(DEPTH) && !wr_reset) |=> overrun); // R3

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !wr_reset) |=> overrun); // R3

   AST_BURST_POP4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_burst && !rx_valid && !wr_reset && count >= CNT_W'(LANES))
      |=> count == $past(count) - CNT_W'(LANES)); // R6

   AST_BURST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_burst && count < CNT_W'(LANES)) |-> acc_rdata[BUS_W-1 -: 8] == 8'h00); // R7

   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_byte |-> acc_rdata[BUS_W-1:8] == '0); // R8

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reset |=> (count == '0) && !overrun); // R9

   AST_STAT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !rx_valid && !acc_wr) |=> $stable(count)); // R10

endmodule

bind uart_rx_burst_fifo rxb_checker #(
   .DEPTH     (DEPTH),
   .ADDR_W    (ADDR_W),
   .BUS_W     (BUS_W),
   .LANES     (LANES),
   .CNT_W     (CNT_W),
   .OFS_BYTE  (OFS_BYTE),
   .OFS_CTRL  (OFS_CTRL),
   .OFS_STAT  (OFS_STAT),
   .OFS_BURST (OFS_BURST),
   .RST_BIT   (RST_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .acc_rd    (acc_rd),
   .acc_wr    (acc_wr),
   .acc_addr  (acc_addr),
   .acc_wdata (acc_wdata),
   .acc_rdata (acc_rdata),
   .count     (fill_cnt),
   .overrun   (ovr_flag)
);

// File: tb/tb_uart_rx_burst_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_burst_fifo;

   localparam int A_BYTE = 'h00, A_CTRL = 'h02, A_STAT = 'h9C, A_BURST = 'hA4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rx_valid, rx_perr, rx_ferr, acc_rd, acc_wr;
   logic [7:0]  rx_byte, acc_addr, acc_wdata;
   logic [31:0] acc_rdata;

   always #2 clk = ~clk;

   uart_rx_burst_fifo dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
   );

   // model entry: [7:0] data, [8] parity tag, [9] framing tag
   bit [9:0] mq[$];
   bit       m_ovr;
   int       n_cmp = 0;
   int       n_bad = 0;
   bit       done = 1'b0;

   function automatic bit [31:0] exp_read(int addr);
      bit [31:0] r = '0;
      int n = mq.size();
      if (addr == A_STAT) begin
         r[7:0] = 8'(n);
         r[20]  = (n == 0) && !m_ovr;
         r[24]  = (n != 0);
         r[25]  = m_ovr;
         if (n != 0) begin
            r[26] = mq[0][8];
            r[27] = mq[0][9];
         end
         foreach (mq[i]) if (mq[i][9:8] != 2'b00) r[31] = 1'b1;
      end else if (addr == A_BURST) begin
         for (int i = 0; i < 4; i++) if (i < n) r[8*i +: 8] = mq[i][7:0];
      end else if (addr == A_BYTE) begin
         if (n != 0) r[7:0] = mq[0][7:0];
      end
      return r;
   endfunction

   task automatic step(bit rv, bit [7:0] d, bit pe, bit fe, bit rd, bit wr,
                       bit [7:0] addr, bit [7:0] wd, string tag);
      int npop;
      bit full_pre;
      bit [31:0] expv;
      @(negedge clk);
      rx_valid = rv; rx_byte = d; rx_perr = pe; rx_ferr = fe;
      acc_rd = rd; acc_wr = wr; acc_addr = addr; acc_wdata = wd;
      #1;
      if (rd) begin
         expv = exp_read(addr);
         n_cmp++;
         if (acc_rdata !== expv) begin
            n_bad++;
            $display("FAIL %s addr=%h got=%h expected=%h", tag, addr, acc_rdata, expv);
         end
      end
      npop = 0;
      if (rd && addr == A_BURST) npop = (mq.size() < 4) ? mq.size() : 4;
      if (rd && addr == A_BYTE)  npop = (mq.size() < 1) ? 0 : 1;
      full_pre = (mq.size() == 64);
      if (wr && addr == A_CTRL && wd[1]) begin
         mq.delete();
         m_ovr = 1'b0;
      end else begin
         repeat (npop) void'(mq.pop_front());
         if (rv) begin
            if (full_pre) m_ovr = 1'b1;
            else mq.push_back({fe, pe, d});
         end
      end
   endtask

   task automatic push(bit [7:0] d, bit pe, bit fe);
      step(1, d, pe, fe, 0, 0, 0, 0, "push");
   endtask

   task automatic rd(bit [7:0] addr, string tag);
      step(0, 0, 0, 0, 1, 0, addr, 0, tag);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      if (!done) begin
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rx_valid = 0; rx_byte = 0; rx_perr = 0; rx_ferr = 0;
      acc_rd = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0; m_ovr = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      rd(A_STAT, "R1 R2 reset status");
      // six bytes, third one parity-tagged
      for (int i = 0; i < 6; i++) push(8'hA0 + 8'(i), i == 2, 0);
      rd(A_STAT, "R1 R4 R5 six queued");
      rd(A_BURST, "R6 full burst lane order");
      rd(A_STAT, "R5 R10 tag left queue");
      rd(A_BURST, "R7 partial burst zero fill");
      rd(A_STAT, "R1 R2 empty after partial");
      rd(A_BYTE, "R8 byte read on empty");
      push(8'h5A, 0, 1);
      rd(A_STAT, "R4 framing head");
      rd(A_BYTE, "R8 byte read");
      rd(8'h40, "R10 unmapped offset");
      // overflow
      for (int i = 0; i < 70; i++) push(8'(i), 0, 0);
      rd(A_STAT, "R3 overrun at full");
      step(0, 0, 0, 0, 0, 1, A_CTRL, 8'h41, "R9 no reset bit");
      rd(A_STAT, "R9 write without reset bit");
      step(1, 8'h77, 1, 0, 0, 1, A_CTRL, 8'h43, "R9 reset write");
      rd(A_STAT, "R9 after reset write");
      // full queue drained while a byte arrives
      for (int i = 0; i < 64; i++) push(8'hC0 ^ 8'(i), 0, 0);
      step(1, 8'hEE, 0, 0, 1, 0, A_BURST, 0, "R11 burst while full");
      rd(A_STAT, "R11 status after");
      step(1, 8'hEF, 0, 1, 1, 0, A_BYTE, 0, "R11 byte pop with arrival");
      rd(A_STAT, "R11 R5 status after arrival");
      step(0, 0, 0, 0, 0, 1, A_CTRL, 8'h43, "R9 clear");

      // random mix
      for (int c = 0; c < 6000; c++) begin
         bit rv = ($urandom_range(0, 1) == 1);
         bit [7:0] d = 8'($urandom);
         bit pe = ($urandom_range(0, 9) == 0);
         bit fe = ($urandom_range(0, 11) == 0);
         int op = $urandom_range(0, 99);
         if (op < 20) step(rv, d, pe, fe, 1, 0, A_STAT, 0, "R1 R2 R4 R5 random status");
         else if (op < 38) step(rv, d, pe, fe, 1, 0, A_BURST, 0, "R6 R7 R11 random burst");
         else if (op < 48) step(rv, d, pe, fe, 1, 0, A_BYTE, 0, "R8 R11 random byte");
         else if (op < 49) step(rv, d, pe, fe, 0, 1, A_CTRL, 8'h43, "R9 random reset");
         else if (op < 51) step(rv, d, pe, fe, 0, 1, A_CTRL, 8'h01, "R9 random no-op write");
         else if (op < 52) step(rv, d, pe, fe, 1, 0, 8'h10, 0, "R10 random unmapped");
         else step(rv, d, pe, fe, 0, 0, 0, 0, "idle");
      end
      rd(A_STAT, "R1 final status");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule